// File: doc/BRIEF.md
# Counter Enable Set/Clear Register

This block keeps the enable bit of each of up to sixteen auxiliary event counters. It drives a 16-bit enable vector to the counters. Software changes that vector through two 32-bit write views that share one store. A write of 1 through the disable view turns a counter off. A write of 1 through the enable view turns a counter on. A 0 written through either view leaves the bit as it was. A read returns the current enable bits, whichever view is named.

Two configuration inputs shape the register. The implemented-counter count limits which bits exist: bits at or above it read as zero, take no writes, and are held at zero in the store. The implemented-group count says whether any counters exist at all. When it is zero, every access is refused and reported as undefined. It is not performed.

Top module: `cnt_en_reg`

## Requirements
- R1: While reset is asserted, and after reset is released, the enable vector is all zero and `rd_valid` and `acc_undef` are low.
- R2: A disable-view write with bit n = 1 drives enable bit n to 0 on the next clock edge. Bits written as 0 keep their value.
- R3: An enable-view write with bit n = 1 drives enable bit n to 1 on the next clock edge, if bit n is implemented. Bits written as 0 keep their value.
- R4: When both views write 1 to the same bit in the same cycle, that bit ends up 0.
- R5: A read returns its response one cycle after the request, with `rd_valid` high for that single cycle.
  - Bits [15:0] of the response give the enable state as it stood before any write made in the request cycle.
  - Bits [31:16] are zero.
- R6: Let N be the implemented-counter count. Bits n ≥ N read as 0, appear as 0 on the enable vector, and are not set by writes. A value of N above 16 acts as 16, and N = 0 makes every bit unimplemented.
- R7: When the group count is zero, an access is not performed.
  - This applies to a read, a disable-view write or an enable-view write.
  - The enable state keeps its value.
  - `acc_undef` pulses high on the next cycle.
  - `rd_valid` stays low.
- R8: Write-data bits [31:16] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_num_cnt | input | 5 | Implemented counter count N |
| cfg_num_grp | input | 4 | Implemented counter group count; zero means no counters |
| rd_req | input | 1 | Read request (either view) |
| clr_we | input | 1 | Disable-view write strobe |
| clr_wdata | input | 32 | Disable-view write data |
| set_we | input | 1 | Enable-view write strobe |
| set_wdata | input | 32 | Enable-view write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| acc_undef | output | 1 | Previous cycle's access was refused as undefined |
| cnt_en | output | 16 | Enable vector to the counters |

## Verification
Two pairs of functions can fall in the same cycle.

**Disable and enable writes.** The bench drives both write strobes in one cycle with overlapping masks. It checks that overlapping bits end at 0 and that the remaining bits follow their own view.

**Read and write.** The bench issues a read together with writes. It expects the response to carry the state from before those writes, and the enable vector to carry the state after them.

A behavioural model tracks the enable word, masking and refusal, and the bench compares its prediction with every output on every clock.

// File: rtl/cnt_en_pkg.sv
package cnt_en_pkg;

    localparam int CE_MAX_CNT = 16;
    localparam int CE_DW      = 32;
    localparam int CE_GW      = 4;

    typedef enum logic [1:0] {
        VIEW_NONE = 2'b00,
        VIEW_CLR  = 2'b01,
        VIEW_SET  = 2'b10,
        VIEW_BOTH = 2'b11
    } wr_view_e;

endpackage

// File: rtl/cnt_en_mask.sv
module cnt_en_mask #(
    parameter int MAX_CNT = 16,
    parameter int CW      = 5
) (
    input  logic [CW-1:0]      num_cnt,
    output logic [MAX_CNT-1:0] impl_mask
);
    // bit i exists when the configured count exceeds i; larger counts saturate
    for (genvar i = 0; i < MAX_CNT; i++) begin : g_bit
        assign impl_mask[i] = (32'(num_cnt) > i);
    end
endmodule

// File: rtl/cnt_en_bitctl.sv
module cnt_en_bitctl #(
    parameter int MAX_CNT = 16
) (
    input  logic [MAX_CNT-1:0] cur_en,
    input  logic [MAX_CNT-1:0] set_bits,
    input  logic [MAX_CNT-1:0] clr_bits,
    input  logic [MAX_CNT-1:0] impl_mask,
    output logic [MAX_CNT-1:0] nxt_en
);
    // per bit: clear dominates set, unimplemented bits are forced low
    for (genvar i = 0; i < MAX_CNT; i++) begin : g_bit
        always_comb begin
            if (!impl_mask[i]) begin
                nxt_en[i] = 1'b0;
            end else if (clr_bits[i]) begin
                nxt_en[i] = 1'b0;
            end else if (set_bits[i]) begin
                nxt_en[i] = 1'b1;
            end else begin
                nxt_en[i] = cur_en[i];
            end
        end
    end
endmodule

// File: rtl/cnt_en_reg.sv
module cnt_en_reg
    import cnt_en_pkg::*;
#(
    parameter  int MAX_CNT = CE_MAX_CNT,
    parameter  int DW      = CE_DW,
    parameter  int GW      = CE_GW,
    localparam int CW      = $clog2(MAX_CNT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CW-1:0]      cfg_num_cnt,
    input  logic [GW-1:0]      cfg_num_grp,
    input  logic               rd_req,
    input  logic               clr_we,
    input  logic [DW-1:0]      clr_wdata,
    input  logic               set_we,
    input  logic [DW-1:0]      set_wdata,
    output logic               rd_valid,
    output logic [DW-1:0]      rd_data,
    output logic               acc_undef,
    output logic [MAX_CNT-1:0] cnt_en
);

    typedef struct packed {
        logic [MAX_CNT-1:0] en;
        logic               rvld;
        logic [DW-1:0]      rdat;
        logic               undef;
    } st_t;

    st_t st_d, st_q;

    logic [MAX_CNT-1:0] impl_mask;
    logic [MAX_CNT-1:0] set_bits;
    logic [MAX_CNT-1:0] clr_bits;
    logic [MAX_CNT-1:0] nxt_en;
    logic               grp_ok;
    wr_view_e           wr_view;
    logic               unused_hi;

    // upper write-data bits are reserved and deliberately dropped
    assign unused_hi = ^{clr_wdata[DW-1:MAX_CNT], set_wdata[DW-1:MAX_CNT]};

    assign grp_ok  = |cfg_num_grp;
    assign wr_view = wr_view_e'({set_we, clr_we});

    cnt_en_mask #(.MAX_CNT(MAX_CNT), .CW(CW)) u_mask (
        .num_cnt   (cfg_num_cnt),
        .impl_mask (impl_mask)
    );

    always_comb begin
        set_bits = '0;
        clr_bits = '0;
        if (grp_ok) begin
            unique case (wr_view)
                VIEW_SET:  set_bits = set_wdata[MAX_CNT-1:0];
                VIEW_CLR:  clr_bits = clr_wdata[MAX_CNT-1:0];
                VIEW_BOTH: begin
                    set_bits = set_wdata[MAX_CNT-1:0];
                    clr_bits = clr_wdata[MAX_CNT-1:0];
                end
                default: ;
            endcase
        end
    end

    cnt_en_bitctl #(.MAX_CNT(MAX_CNT)) u_bitctl (
        .cur_en    (st_q.en),
        .set_bits  (set_bits),
        .clr_bits  (clr_bits),
        .impl_mask (impl_mask),
        .nxt_en    (nxt_en)
    );

    always_comb begin
        st_d       = st_q;
        st_d.en    = nxt_en;
        st_d.rvld  = rd_req && grp_ok;
        st_d.rdat  = '0;
        st_d.undef = (rd_req || clr_we || set_we) && !grp_ok;
        if (rd_req && grp_ok) begin
            st_d.rdat[MAX_CNT-1:0] = st_q.en & impl_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_en    = st_q.en & impl_mask;
    assign rd_valid  = st_q.rvld;
    assign rd_data   = st_q.rdat;
    assign acc_undef = st_q.undef;

endmodule

// File: rtl/cnt_en_chk.sv
module cnt_en_chk #(
    parameter  int MAX_CNT = 16,
    parameter  int DW      = 32,
    parameter  int GW      = 4,
    localparam int CW      = $clog2(MAX_CNT + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CW-1:0]      cfg_num_cnt,
    input logic [GW-1:0]      cfg_num_grp,
    input logic               rd_req,
    input logic               clr_we,
    input logic [DW-1:0]      clr_wdata,
    input logic               set_we,
    input logic [DW-1:0]      set_wdata,
    input logic               rd_valid,
    input logic [DW-1:0]      rd_data,
    input logic               acc_undef,
    input logic [MAX_CNT-1:0] cnt_en
);

    logic [MAX_CNT-1:0] exist;
    logic               any_acc;
    logic               grp_zero;

    always_comb begin
        for (int i = 0; i < MAX_CNT; i++) begin
            exist[i] = (int'(cfg_num_cnt) > i);
        end
    end

    assign any_acc  = rd_req || clr_we || set_we;
    assign grp_zero = (cfg_num_grp == '0);

    // R1: the cycle after reset is seen, the enable vector is still zero
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (cnt_en == '0 && !rd_valid && !acc_undef));

    // R2 / R4: a bit written 1 through the disable view is off afterwards
    a_r2_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !grp_zero) |=> ((cnt_en & $past(clr_wdata[MAX_CNT-1:0])) == '0));

    // R3: a bit written 1 through the enable view alone is on afterwards
    a_r3_set_on: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we && !grp_zero) |=>
        (!$stable(cfg_num_cnt) ||
         ((cnt_en & $past(set_wdata[MAX_CNT-1:0] & exist)) ==
          $past(set_wdata[MAX_CNT-1:0] & exist))));

    // R5: reserved read-data bits are zero
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[DW-1:MAX_CNT] == '0));

    // R5: a read response follows exactly one accepted request
    a_r5_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !grp_zero) |=> rd_valid);

    // R6: unimplemented bits never show on the enable vector
    a_r6_unimpl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_en & ~exist) == '0));

    // R7: refused access flags undefined and returns no data
    a_r7_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (any_acc && grp_zero) |=> (acc_undef && !rd_valid));

    // R7: refused cycle leaves enables unchanged
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        grp_zero |=> (!$stable(cfg_num_cnt) || $stable(cnt_en)));

endmodule

bind cnt_en_reg cnt_en_chk #(.MAX_CNT(MAX_CNT), .DW(DW), .GW(GW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_num_cnt (cfg_num_cnt),
    .cfg_num_grp (cfg_num_grp),
    .rd_req      (rd_req),
    .clr_we      (clr_we),
    .clr_wdata   (clr_wdata),
    .set_we      (set_we),
    .set_wdata   (set_wdata),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .acc_undef   (acc_undef),
    .cnt_en      (cnt_en)
);

// File: tb/cnt_en_reg_bench.sv
module cnt_en_reg_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_num_cnt = 5'd16;
    logic [3:0]  cfg_num_grp = 4'd1;
    logic        rd_req = 1'b0;
    logic        clr_we = 1'b0;
    logic [31:0] clr_wdata = '0;
    logic        set_we = 1'b0;
    logic [31:0] set_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        acc_undef;
    logic [15:0] cnt_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // behavioural model state
    int unsigned m_en = 0;
    bit          e_rv = 1'b0;
    int unsigned e_rd = 0;
    bit          e_und = 1'b0;

    cnt_en_reg u_cnt_en_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_num_cnt (cfg_num_cnt),
        .cfg_num_grp (cfg_num_grp),
        .rd_req      (rd_req),
        .clr_we      (clr_we),
        .clr_wdata   (clr_wdata),
        .set_we      (set_we),
        .set_wdata   (set_wdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .acc_undef   (acc_undef),
        .cnt_en      (cnt_en)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic int unsigned mfn(input int n);
        if (n >= 16) return 32'h0000_FFFF;
        return (32'd1 << n) - 32'd1;
    endfunction

    task automatic check(input string req, input string what,
                         input int unsigned act, input int unsigned exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        check(req, "cnt_en", 32'(cnt_en), m_en & mfn(int'(cfg_num_cnt)));
        check(req, "rd_valid", 32'(rd_valid), 32'(e_rv));
        if (e_rv) check(req, "rd_data", rd_data, e_rd);
        check(req, "acc_undef", 32'(acc_undef), 32'(e_und));
    endtask

    // called at a falling edge: drive, predict, cross one rising edge, compare
    task automatic step(input bit rd, input bit cw, input logic [31:0] cd,
                        input bit sw, input logic [31:0] sd, input string req);
        int unsigned mask;
        int unsigned nxt;
        rd_req = rd; clr_we = cw; clr_wdata = cd; set_we = sw; set_wdata = sd;
        mask = mfn(int'(cfg_num_cnt));
        nxt  = m_en & mask;
        if (cfg_num_grp == 0) begin
            e_rv  = 1'b0;
            e_und = rd || cw || sw;
        end else begin
            e_rv  = rd;
            e_und = 1'b0;
            if (rd) e_rd = m_en & mask;
            if (sw) nxt = nxt | (sd & 32'hFFFF & mask);
            if (cw) nxt = nxt & ~(cd & 32'hFFFF);
        end
        @(posedge clk);
        m_en = nxt;
        @(negedge clk);
        compare_all(req);
        rd_req = 1'b0; clr_we = 1'b0; set_we = 1'b0;
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, '0, 1'b0, '0, req);
    endtask

    initial begin
        @(negedge clk);
        // R1: during reset
        check("R1", "cnt_en", 32'(cnt_en), 0);
        check("R1", "rd_valid", 32'(rd_valid), 0);
        check("R1", "acc_undef", 32'(acc_undef), 0);
        rst_n = 1'b1;
        idle("R1");

        // R3: enable through set view, then read back
        step(1'b0, 1'b0, '0, 1'b1, 32'h0000_A5C3, "R3");
        step(1'b1, 1'b0, '0, 1'b0, '0, "R5");
        step(1'b0, 1'b0, '0, 1'b1, 32'h0000_0004, "R3");
        // R2: disable through clear view; zeros leave bits
        step(1'b0, 1'b1, 32'h0000_8001, 1'b0, '0, "R2");
        step(1'b1, 1'b0, '0, 1'b0, '0, "R2");
        // R4: simultaneous overlapping set and clear
        step(1'b0, 1'b1, 32'h0000_00F0, 1'b1, 32'h0000_0FF0, "R4");
        step(1'b1, 1'b0, '0, 1'b0, '0, "R4");
        // R5: read in the same cycle as writes returns pre-write state
        step(1'b1, 1'b1, 32'h0000_0003, 1'b1, 32'h0000_F000, "R5");
        step(1'b1, 1'b0, '0, 1'b0, '0, "R5");
        // R8: reserved write-data bits change nothing
        step(1'b0, 1'b1, 32'hFFFF_0000, 1'b1, 32'hFFFF_0000, "R8");
        step(1'b1, 1'b0, '0, 1'b0, '0, "R8");
        // R6: shrink N, writes above N ignored, read masks
        cfg_num_cnt = 5'd5;
        step(1'b1, 1'b0, '0, 1'b1, 32'h0000_FFFF, "R6");
        step(1'b1, 1'b0, '0, 1'b0, '0, "R6");
        cfg_num_cnt = 5'd16;
        step(1'b1, 1'b0, '0, 1'b0, '0, "R6");
        cfg_num_cnt = 5'd20;
        step(1'b0, 1'b0, '0, 1'b1, 32'h0000_FFFF, "R6");
        step(1'b1, 1'b0, '0, 1'b0, '0, "R6");
        cfg_num_cnt = 5'd0;
        step(1'b1, 1'b0, '0, 1'b1, 32'h0000_FFFF, "R6");
        cfg_num_cnt = 5'd16;
        step(1'b1, 1'b0, '0, 1'b1, 32'h0000_3C3C, "R6");
        // R7: no groups; every access refused
        cfg_num_grp = 4'd0;
        step(1'b1, 1'b0, '0, 1'b0, '0, "R7");
        step(1'b0, 1'b1, 32'h0000_FFFF, 1'b0, '0, "R7");
        step(1'b0, 1'b0, '0, 1'b1, 32'h0000_FFFF, "R7");
        idle("R7");
        cfg_num_grp = 4'd3;
        step(1'b1, 1'b0, '0, 1'b0, '0, "R7");
        // R2: clear everything
        step(1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, '0, "R2");
        step(1'b1, 1'b0, '0, 1'b0, '0, "R2");
        // R1: reset mid-run clears state
        step(1'b0, 1'b0, '0, 1'b1, 32'h0000_00FF, "R3");
        rst_n = 1'b0;
        m_en = 0; e_rv = 1'b0; e_und = 1'b0;
        @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        idle("R1");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule